// File: doc/BRIEF.md
# Tile Inclusive Prefix-Sum Engine

This block takes one tile of integer elements, 256 of them by default, and produces the running total at every position: result k is the sum of inputs 0 through k, wrapping modulo 2^W. A start pulse supplies how many elements are meaningful. That many elements then arrive over a ready/valid stream. Every slot above that count is filled with zero. The tile is then reduced in place with a log-step schedule. In pass p each position adds in the value held 2^p slots below it, provided such a slot exists. After log2(256) = 8 passes every slot holds its full prefix. The meaningful results leave over a second ready/valid stream, and the final one is flagged.

A pass must read only values left by the previous pass. A pass boundary is therefore a hard barrier. The block meets this with two storage banks used in turn: each pass reads one bank and writes the other. A configurable group of lanes is processed every cycle, so one pass lasts TILE_N/LANES cycles.

The controller is a five-state machine:
- IDLE: waiting for a start pulse.
- LOAD: accepting the meaningful elements.
- FILL: writing zeros into the remaining slots.
- SCAN: running the passes.
- DRAIN: emitting results.

Its transitions are:
- IDLE→LOAD: start with a nonzero count.
- IDLE→FILL: start with a zero count.
- LOAD→FILL: last element taken while the count is below the tile size.
- LOAD→SCAN: last element taken with a full tile.
- FILL→SCAN: top slot zeroed.
- SCAN→DRAIN: final group of the final pass, with a nonzero count.
- SCAN→IDLE: final group of the final pass, with a zero count.
- DRAIN→IDLE: last result accepted.

Top module: `prefix_scan_tile`

## Requirements
- R1: After reset, busy, in_ready and out_valid are all 0.
- R2: A start pulse seen in IDLE captures count_in, clamped to 256 when larger, and busy is 1 from the next cycle.
- R3: In LOAD, in_ready is 1 and exactly count elements are taken in arrival order as slots 0..count−1. In_ready is 0 once the last one is taken.
- R4: Slots at or above count act as zero and produce no output: exactly count results are emitted, and none when count is 0.
- R5: Result k equals the sum of inputs 0..k, and results leave in ascending order of k.
- R6: All sums wrap modulo 2^DATA_W.
- R7: out_valid stays 0 until all 8 passes are done. The first result is presented exactly 512 − count cycles after the clock edge that takes the last input.
- R8: A start pulse while busy is ignored: in_ready stays 0, and the count and results of the tile in flight are unchanged.
- R9: out_last is 1 exactly on the final result. While out_valid is 1 and out_ready is 0, out_data and out_last hold.
- R10: busy returns to 0 after the last result is accepted. With count 0, busy falls 512 cycles after the start edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a tile (used only when idle) |
| count_in | input | 9 | Number of meaningful elements, 0..256 |
| in_valid | input | 1 | Input element valid |
| in_ready | output | 1 | Block can take an input element |
| in_data | input | DATA_W | Input element |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | DATA_W | Inclusive prefix sum |
| out_last | output | 1 | Marks the final result |
| busy | output | 1 | A tile is being processed |

## Verification
The hardest cases to reach from the ports are stale bank contents and a start pulse arriving mid-tile.

A partial tile only proves that slots above the count are ignored if those slots still hold nonzero values from an earlier tile. The stimulus therefore runs a full random tile before the 255-element tile. The 255-element tile also receives a second start pulse after loading, during the zero fill and scan.

Wrapping needs sums that exceed 2^16 many times over, so one full tile is filled with all-ones words. Output backpressure is randomized on some tiles to exercise the hold rule.

// File: rtl/scan_pkg.sv
package scan_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_FILL,
        ST_SCAN,
        ST_DRAIN
    } scan_state_e;

endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
    import scan_pkg::*;
#(
    parameter int TILE_N = 256,
    parameter int LANES  = 8,
    localparam int IDX_W  = $clog2(TILE_N),
    localparam int CNT_W  = IDX_W + 1,
    localparam int PASSES = IDX_W,
    localparam int PASS_W = (PASSES > 1) ? $clog2(PASSES) : 1,
    localparam int GROUPS = TILE_N / LANES,
    localparam int GRP_W  = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int LANE_SH = $clog2(LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              in_valid,
    input  logic              out_ready,
    output logic              in_ready,
    output logic              load_we,
    output logic              load_zero,
    output logic [IDX_W-1:0]  wr_idx,
    output logic              lane_we,
    output logic [PASS_W-1:0] pass_idx,
    output logic [IDX_W-1:0]  grp_base,
    output logic              out_valid,
    output logic              out_last,
    output logic [IDX_W-1:0]  rd_idx,
    output logic              busy
);

    scan_state_e       state_q, state_d;
    logic [CNT_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [PASS_W-1:0] pass_q;
    logic [GRP_W-1:0]  grp_q;

    logic [CNT_W-1:0]  cnt_clamped;
    logic              take_in;
    logic              take_out;
    logic              idx_at_last;
    logic              fill_end;
    logic              grp_end;
    logic              pass_end;

    assign cnt_clamped = (count_in > CNT_W'(TILE_N)) ? CNT_W'(TILE_N) : count_in;
    assign take_in     = (state_q == ST_LOAD) && in_valid;
    assign take_out    = (state_q == ST_DRAIN) && out_ready;
    assign idx_at_last = (idx_q == cnt_q - 1'b1);
    assign fill_end    = (idx_q == CNT_W'(TILE_N - 1));
    assign grp_end     = (grp_q == GRP_W'(GROUPS - 1));
    assign pass_end    = (pass_q == PASS_W'(PASSES - 1));

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (cnt_clamped == '0) ? ST_FILL : ST_LOAD;
                end
            end
            ST_LOAD: begin
                if (take_in && idx_at_last) begin
                    state_d = (cnt_q == CNT_W'(TILE_N)) ? ST_SCAN : ST_FILL;
                end
            end
            ST_FILL: begin
                if (fill_end) begin
                    state_d = ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (grp_end && pass_end) begin
                    state_d = (cnt_q == '0) ? ST_IDLE : ST_DRAIN;
                end
            end
            ST_DRAIN: begin
                if (take_out && idx_at_last) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register and its counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            cnt_q   <= '0;
            pass_q  <= '0;
            grp_q   <= '0;
        end else begin
            state_q <= state_d;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cnt_q  <= cnt_clamped;
                        idx_q  <= '0;
                        pass_q <= '0;
                        grp_q  <= '0;
                    end
                end
                ST_LOAD: begin
                    if (take_in) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_FILL: begin
                    idx_q <= idx_q + 1'b1;
                end
                ST_SCAN: begin
                    if (grp_end) begin
                        grp_q  <= '0;
                        pass_q <= pass_q + 1'b1;
                    end else begin
                        grp_q <= grp_q + 1'b1;
                    end
                    if (grp_end && pass_end) begin
                        idx_q <= '0;
                    end
                end
                ST_DRAIN: begin
                    if (take_out) begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs decoded from the state
    always_comb begin
        in_ready  = 1'b0;
        load_we   = 1'b0;
        load_zero = 1'b0;
        lane_we   = 1'b0;
        out_valid = 1'b0;
        out_last  = 1'b0;
        busy      = 1'b0;
        wr_idx    = idx_q[IDX_W-1:0];
        rd_idx    = idx_q[IDX_W-1:0];
        pass_idx  = pass_q;
        grp_base  = IDX_W'(grp_q) << LANE_SH;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD: begin
                busy     = 1'b1;
                in_ready = 1'b1;
                load_we  = in_valid;
            end
            ST_FILL: begin
                busy      = 1'b1;
                load_we   = 1'b1;
                load_zero = 1'b1;
            end
            ST_SCAN: begin
                busy    = 1'b1;
                lane_we = 1'b1;
            end
            ST_DRAIN: begin
                busy      = 1'b1;
                out_valid = 1'b1;
                out_last  = idx_at_last;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/scan_banks.sv
module scan_banks #(
    parameter int DATA_W = 16,
    parameter int TILE_N = 256,
    parameter int LANES  = 8,
    localparam int IDX_W = $clog2(TILE_N)
) (
    input  logic                          clk,
    input  logic                          load_we,
    input  logic                          load_zero,
    input  logic [IDX_W-1:0]              load_idx,
    input  logic [DATA_W-1:0]             load_data,
    input  logic                          lane_we,
    input  logic                          lane_dst,
    input  logic [IDX_W-1:0]              lane_base,
    input  logic [LANES-1:0][DATA_W-1:0]  lane_data,
    output logic [DATA_W-1:0]             bank0_q [TILE_N],
    output logic [DATA_W-1:0]             bank1_q [TILE_N]
);

    // Two banks used in turn: a pass reads one and fills the other,
    // so no slot is read after it has been overwritten in the same pass.
    always_ff @(posedge clk) begin
        if (load_we) begin
            bank0_q[load_idx] <= load_zero ? '0 : load_data;
        end
        if (lane_we) begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_dst) begin
                    bank1_q[lane_base + IDX_W'(k)] <= lane_data[k];
                end else begin
                    bank0_q[lane_base + IDX_W'(k)] <= lane_data[k];
                end
            end
        end
    end

endmodule

// File: rtl/scan_lane.sv
module scan_lane #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 8
) (
    input  logic [IDX_W-1:0]  pos,
    input  logic [IDX_W-1:0]  stride,
    input  logic [DATA_W-1:0] own_val,
    input  logic [DATA_W-1:0] lower_val,
    output logic [DATA_W-1:0] new_val
);

    // Slots below the stride have no partner and keep their value.
    always_comb begin
        if (pos >= stride) begin
            new_val = own_val + lower_val;
        end else begin
            new_val = own_val;
        end
    end

endmodule

// File: rtl/prefix_scan_tile.sv
module prefix_scan_tile #(
    parameter int DATA_W = 16,
    parameter int TILE_N = 256,
    parameter int LANES  = 8,
    localparam int IDX_W  = $clog2(TILE_N),
    localparam int CNT_W  = IDX_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              busy
);

    localparam int PASSES   = IDX_W;
    localparam int PASS_W   = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam bit RES_BANK = (PASSES % 2) == 1;

    logic                         load_we;
    logic                         load_zero;
    logic [IDX_W-1:0]             wr_idx;
    logic                         lane_we;
    logic [PASS_W-1:0]            pass_idx;
    logic [IDX_W-1:0]             grp_base;
    logic [IDX_W-1:0]             rd_idx;
    logic [IDX_W-1:0]             stride;
    logic                         src_sel;
    logic [LANES-1:0][DATA_W-1:0] lane_data;
    logic [DATA_W-1:0]            bank0 [TILE_N];
    logic [DATA_W-1:0]            bank1 [TILE_N];

    scan_ctrl #(
        .TILE_N (TILE_N),
        .LANES  (LANES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .count_in  (count_in),
        .in_valid  (in_valid),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .load_we   (load_we),
        .load_zero (load_zero),
        .wr_idx    (wr_idx),
        .lane_we   (lane_we),
        .pass_idx  (pass_idx),
        .grp_base  (grp_base),
        .out_valid (out_valid),
        .out_last  (out_last),
        .rd_idx    (rd_idx),
        .busy      (busy)
    );

    assign stride  = IDX_W'(1) << pass_idx;
    assign src_sel = pass_idx[0];

    scan_banks #(
        .DATA_W (DATA_W),
        .TILE_N (TILE_N),
        .LANES  (LANES)
    ) u_banks (
        .clk       (clk),
        .load_we   (load_we),
        .load_zero (load_zero),
        .load_idx  (wr_idx),
        .load_data (in_data),
        .lane_we   (lane_we),
        .lane_dst  (~src_sel),
        .lane_base (grp_base),
        .lane_data (lane_data),
        .bank0_q   (bank0),
        .bank1_q   (bank1)
    );

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [IDX_W-1:0]  pos;
        logic [IDX_W-1:0]  lower_pos;
        logic [DATA_W-1:0] own_val;
        logic [DATA_W-1:0] lower_val;

        assign pos       = grp_base + IDX_W'(k);
        assign lower_pos = pos - stride;
        assign own_val   = src_sel ? bank1[pos] : bank0[pos];
        assign lower_val = src_sel ? bank1[lower_pos] : bank0[lower_pos];

        scan_lane #(
            .DATA_W (DATA_W),
            .IDX_W  (IDX_W)
        ) u_lane (
            .pos       (pos),
            .stride    (stride),
            .own_val   (own_val),
            .lower_val (lower_val),
            .new_val   (lane_data[k])
        );
    end

    if (RES_BANK) begin : g_res_b1
        assign out_data = bank1[rd_idx];
    end else begin : g_res_b0
        assign out_data = bank0[rd_idx];
    end

endmodule

// File: rtl/scan_checker.sv
module scan_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              in_valid,
    input logic              in_ready,
    input logic [DATA_W-1:0] in_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last
);

    logic              armed_q;
    logic [DATA_W-1:0] first_q;

    // remembers the first element of each tile
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            first_q <= '0;
        end else if (start && !busy) begin
            armed_q <= 1'b1;
        end else if (armed_q && in_valid && in_ready) begin
            armed_q <= 1'b0;
            first_q <= in_data;
        end
    end

    // R3: input side open only while a tile is in flight
    a_r3_ready_needs_busy: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> busy);

    // R7: no result while elements are still arriving
    a_r7_no_out_in_load: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !out_valid);

    // R8: a start pulse mid-tile does not reopen the input side
    a_r8_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !in_ready) |=> !in_ready);

    // R9: stalled result holds
    a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

    // R5: first result equals the first element loaded
    a_r5_first_result: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (out_data == first_q));

endmodule

bind prefix_scan_tile scan_checker #(.DATA_W(DATA_W)) u_scan_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/prefix_scan_tile_bench.sv
`timescale 1ns/1ps
module prefix_scan_tile_bench;

    localparam int DATA_W = 16;
    localparam int TILE_N = 256;
    localparam int CNT_W  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [CNT_W-1:0]  count_in = '0;
    logic              in_valid = 1'b0;
    logic              in_ready;
    logic [DATA_W-1:0] in_data = '0;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [DATA_W-1:0] out_data;
    logic              out_last;
    logic              busy;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int last_acc_cyc = 0;
    int exp_lat = 0;
    bit want_lat = 0;
    bit lat_seen = 0;
    bit bp_en = 0;
    bit done = 0;

    logic [DATA_W-1:0] exp_q[$];
    bit                exp_last_q[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    prefix_scan_tile u_prefix_scan_tile (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .count_in  (count_in),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data),
        .out_last  (out_last),
        .busy      (busy)
    );

    task automatic check(bit ok, string req, string what, longint act, longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    // monitor: pops the scoreboard as results are accepted
    always @(negedge clk) begin
        out_ready = bp_en ? (($urandom % 4) != 0) : 1'b1;
        #1;
        if (rst_n && out_valid) begin
            if (want_lat && !lat_seen) begin
                lat_seen = 1;
                check(cyc - last_acc_cyc == exp_lat, "R7", "first result latency",
                      cyc - last_acc_cyc, exp_lat);
            end
            if (out_ready) begin
                if (exp_q.size() == 0) begin
                    check(0, "R4", "unexpected result", out_data, 0);
                end else begin
                    logic [DATA_W-1:0] e;
                    bit el;
                    e  = exp_q.pop_front();
                    el = exp_last_q.pop_front();
                    check(out_data == e, "R5", "prefix sum", out_data, e);
                    check(out_last == el, "R9", "last flag", out_last, el);
                end
            end
        end
    end

    // driver: loads one tile and records the expected results
    task automatic run_tile(int cnt, int mode, bit poke);
        logic [DATA_W-1:0] d [TILE_N];
        logic [DATA_W-1:0] acc;
        int eff;
        int start_cyc;
        eff = (cnt > TILE_N) ? TILE_N : cnt;
        acc = '0;
        for (int k = 0; k < TILE_N; k++) begin
            case (mode)
                1: d[k] = '1;
                2: d[k] = DATA_W'(k * 3 + 1);
                default: d[k] = DATA_W'($urandom);
            endcase
        end
        for (int k = 0; k < eff; k++) begin
            acc = acc + d[k];
            exp_q.push_back(acc);
            exp_last_q.push_back(k == eff - 1);
        end
        want_lat = (eff > 0);
        lat_seen = 0;
        exp_lat  = 512 - eff;

        @(negedge clk);
        start = 1'b1;
        count_in = CNT_W'(cnt);
        @(posedge clk);
        #1 start_cyc = cyc;
        @(negedge clk);
        start = 1'b0;
        check(busy == 1'b1, "R2", "busy after start", busy, 1);

        for (int k = 0; k < eff; k++) begin
            bit acc_ok;
            if (($urandom % 3) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = d[k];
            acc_ok = 0;
            while (!acc_ok) begin
                acc_ok = in_ready;
                @(posedge clk);
                #1;
                if (!acc_ok) @(negedge clk);
            end
            last_acc_cyc = cyc;
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_data  = '0;
        if (eff > 0) begin
            check(in_ready == 1'b0, "R3", "in_ready after last element", in_ready, 0);
        end

        if (poke) begin
            start = 1'b1;
            count_in = CNT_W'(5);
            @(negedge clk);
            start = 1'b0;
            check(in_ready == 1'b0, "R8", "in_ready after start while busy", in_ready, 0);
            check(busy == 1'b1, "R8", "busy after start while busy", busy, 1);
        end

        while (busy) @(negedge clk);
        #2;
        check(exp_q.size() == 0, "R4", "results left unemitted", exp_q.size(), 0);
        if (eff == 0) begin
            check(cyc - start_cyc == 512, "R10", "busy span for empty tile",
                  cyc - start_cyc, 512);
            check(lat_seen == 0, "R4", "no result for empty tile", lat_seen, 0);
        end else begin
            check(lat_seen == 1, "R10", "busy fell after results", lat_seen, 1);
        end
        exp_q.delete();
        exp_last_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "WATCHDOG", "run timed out", cyc, 200000);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(in_ready == 1'b0, "R1", "in_ready after reset", in_ready, 0);
        check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

        run_tile(256, 0, 0);   // R5 full random tile
        run_tile(1, 0, 0);     // R4 single element
        run_tile(255, 0, 1);   // R4 R8 stale banks, mid-tile start
        run_tile(0, 0, 0);     // R10 empty tile
        run_tile(256, 1, 0);   // R6 all-ones wrap
        bp_en = 1;
        run_tile(100, 2, 0);   // R9 backpressure
        run_tile(300, 0, 0);   // R2 clamp to 256
        run_tile(256, 0, 0);   // R9 full tile under backpressure
        bp_en = 0;
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule